// File: doc/BRIEF.md
# Scaled Timeout Timer

This block measures protocol timeouts in fixed decade time units. A prescaler divides the system clock down to a tick period of 10 µs, 100 µs or 1 ms. A 16-bit counter advances once per tick while the timer is enabled. When the count equals a programmed timeout value on a tick, the block sets a sticky status flag. That flag drives an interrupt output through an interrupt-enable gate.

Software drives a one-cycle control write. The write carries the enable, the mode, the time-base select and a restart request. The block has two modes:

- In one-shot mode the timer disarms itself at the timeout and freezes the count.
- In free-running mode the count reloads to zero and the timer keeps running, so it raises a timeout every (timeout + 1) ticks.

The status flag is cleared by a write-one-to-clear pulse. All control and status pins are plain levels or single-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `stt_timer`

## Requirements
- R1: After reset, `count` is 0 and `timer_on`, `status` and `irq` are 0.
- R2: `ctrl_scale` selects the tick period in system clocks: 0 gives CLK_HZ/100000, 1 gives CLK_HZ/10000, 2 gives CLK_HZ/1000. With the timer armed at clock edge E0 and no timeout yet, `count` after edge E0+N equals N divided by the tick period, rounded down.
- R3: While enabled, `count` changes only by stepping up by one on a tick, or by returning to 0.
- R4: A control write with `ctrl_en`=0 forces `count` to 0 and stops the timer. A control write with `ctrl_restart`=1 zeroes both `count` and the prescaler phase.
- R5: One-shot mode (`ctrl_mode`=0) behaves as follows. On the tick where `count` equals `timeout`, `status` is set and `timer_on` drops. `count` then holds at `timeout`.
- R6: Free-running mode (`ctrl_mode`=1) behaves as follows. On the tick where `count` equals `timeout`, `status` is set and `count` reloads to 0. `timer_on` stays 1, so `count` after N edges is (N / period) mod (timeout+1).
- R7: With `ctrl_scale`=3 (reserved), no tick occurs and `count` does not advance.
- R8: `irq` is 1 exactly when `status` is 1 and `irq_en` is 1.
- R9: A `status_w1c` pulse clears `status`. A timeout in the same cycle wins, and `status` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | One-cycle control write strobe |
| ctrl_en | input | 1 | Enable value written |
| ctrl_mode | input | 1 | Mode written: 0 one-shot, 1 free-running |
| ctrl_scale | input | 2 | Time base written: 0 10 µs, 1 100 µs, 2 1 ms, 3 stopped |
| ctrl_restart | input | 1 | With `ctrl_we`, zero the count and prescaler |
| timeout | input | 16 | Timeout value compared on each tick |
| irq_en | input | 1 | Interrupt enable |
| status_w1c | input | 1 | Write-one-to-clear pulse for the status flag |
| timer_on | output | 1 | Current enable state |
| count | output | 16 | Current tick count |
| status | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase appears at `count` within one tick period. It shows as a count that is off by one against the closed-form value N / period. A wrong compare or reload first shows at the timeout tick. The fault is visible as a missing or early `status` rise, or as `count` failing to return to 0. In one-shot mode it is also visible as `timer_on` failing to drop. Every later sample then disagrees. Faults in status priority show only in the exact cycle where a clear pulse coincides with a timeout, so that cycle is driven directly.

// File: rtl/stt_pkg.sv
package stt_pkg;
  typedef enum logic [1:0] {
    BASE_10US  = 2'b00,
    BASE_100US = 2'b01,
    BASE_1MS   = 2'b10,
    BASE_OFF   = 2'b11
  } tbase_e;

  // System clocks per tick for a time base; 0 for the stopped setting.
  function automatic int unsigned base_div(int unsigned clk_hz, logic [1:0] sel);
    case (sel)
      BASE_10US:  return clk_hz / 100000;
      BASE_100US: return clk_hz / 10000;
      BASE_1MS:   return clk_hz / 1000;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/stt_prescaler.sv
module stt_prescaler #(
  parameter int unsigned CLK_HZ = 100_000_000,
  localparam int unsigned DIV_MAX = CLK_HZ / 1000,
  localparam int PW = $clog2(DIV_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] scale,
  output logic       tick
);
  import stt_pkg::*;

  logic [PW-1:0] phase;
  logic [PW-1:0] last;
  logic          live;

  always_comb begin
    last = PW'(base_div(CLK_HZ, scale) - 1);
    live = run && (scale != BASE_OFF);
    // >= keeps the divider sane when the scale shrinks mid-period
    tick = live && (phase >= last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase <= '0;
    else if (!live || restart || tick) phase <= '0;
    else                            phase <= phase + 1'b1;
  end
endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          zero,
  input  logic          free_run,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          hit
);
  assign hit = tick && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (zero)   count <= '0;
    else if (hit)    count <= free_run ? '0 : count;
    else if (tick)   count <= count + 1'b1;
  end
endmodule

// File: rtl/stt_status.sv
module stt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/stt_timer.sv
module stt_timer #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int          CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             ctrl_en,
  input  logic             ctrl_mode,
  input  logic [1:0]       ctrl_scale,
  input  logic             ctrl_restart,
  input  logic [CNT_W-1:0] timeout,
  input  logic             irq_en,
  input  logic             status_w1c,
  output logic             timer_on,
  output logic [CNT_W-1:0] count,
  output logic             status,
  output logic             irq
);
  logic       en_q, mode_q;
  logic [1:0] scale_q;
  logic       tick, hit, zero;

  assign zero = ctrl_we && (!ctrl_en || ctrl_restart);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      scale_q <= 2'b00;
    end else if (ctrl_we) begin
      en_q    <= ctrl_en;
      mode_q  <= ctrl_mode;
      scale_q <= ctrl_scale;
    end else if (hit && !mode_q) begin
      en_q    <= 1'b0;
    end
  end

  assign timer_on = en_q;

  stt_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(zero),
    .scale(scale_q), .tick(tick)
  );

  stt_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .zero(zero),
    .free_run(mode_q), .limit(timeout), .count(count), .hit(hit)
  );

  stt_status u_stat (
    .clk(clk), .rst_n(rst_n), .set(hit), .clr(status_w1c),
    .irq_en(irq_en), .flag(status), .irq(irq)
  );
endmodule

// File: rtl/stt_timer_chk.sv
module stt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic             ctrl_en,
  input logic             status_w1c,
  input logic             timer_on,
  input logic [CNT_W-1:0] count,
  input logic             status,
  input logic             mode_q,
  input logic [1:0]       scale_q
);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_on && !$stable(count)) |-> (count == 0 || count == $past(count) + 1'b1));

  assert_disable_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_en) |=> (count == 0 && !timer_on));

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status) && !mode_q && !$past(ctrl_we)) |-> !timer_on);

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status) && mode_q && !$past(ctrl_we)) |-> (timer_on && count == 0));

  assert_reserved_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_on && scale_q == 2'b11 && !ctrl_we) |=> $stable(count));

  assert_clear_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> $past(status_w1c));
endmodule

bind stt_timer stt_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_stt_timer.sv
`timescale 1ns/1ps
module tb_stt_timer;
  localparam int unsigned CLK_HZ = 200_000;

  logic        clk = 0, rst_n = 0;
  logic        ctrl_we = 0, ctrl_en = 0, ctrl_mode = 0, ctrl_restart = 0;
  logic [1:0]  ctrl_scale = 0;
  logic [15:0] timeout = 0;
  logic        irq_en = 0, status_w1c = 0;
  logic        timer_on, status, irq;
  logic [15:0] count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stt_timer #(.CLK_HZ(CLK_HZ)) dut (.*);

  function automatic int period_of(int s);
    return (s == 0) ? CLK_HZ/100000 : (s == 1) ? CLK_HZ/10000 : CLK_HZ/1000;
  endfunction
  function automatic int exp_count(int n, int p, int t, bit fr);
    int k = n / p;
    if (fr) return k % (t + 1);
    return (k <= t) ? k : t;
  endfunction
  function automatic bit exp_status(int n, int p, int t);
    return (n / p) >= t + 1;
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // control write captured at the next posedge; returns just after it
  task automatic ctl(bit en, bit md, logic [1:0] sc, bit rs, bit w1c);
    @(negedge clk);
    ctrl_we = 1; ctrl_en = en; ctrl_mode = md; ctrl_scale = sc;
    ctrl_restart = rs; status_w1c = w1c;
    @(posedge clk); #1;
    ctrl_we = 0; ctrl_restart = 0; status_w1c = 0;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  initial begin
    void'($urandom(32'd2718));
    #2;
    check("R1 count", count, 0);
    check("R1 timer_on", timer_on, 0);
    check("R1 status", status, 0);
    check("R1 irq", irq, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R7: reserved scale holds count
    timeout = 16'd100;
    ctl(1, 1, 2'b11, 1, 0);
    wait_edges(500);
    check("R7 count", count, 0);
    check("R7 timer_on", timer_on, 1);

    // R4: restart zeroes count and prescaler
    ctl(1, 1, 2'b00, 1, 0);
    wait_edges(50);
    check("R2 count scale0", count, 25);
    ctl(1, 1, 2'b00, 1, 0);
    wait_edges(9);
    check("R4 restart", count, 4);
    ctl(0, 1, 2'b00, 0, 0);
    #3;
    check("R4 disable count", count, 0);
    check("R4 disable on", timer_on, 0);

    // R9: timeout on the same cycle as a clear pulse wins
    timeout = 16'd2;
    ctl(1, 1, 2'b00, 1, 0);
    repeat (5) @(posedge clk);
    #1 status_w1c = 1;
    @(posedge clk); #1 status_w1c = 0;
    #2;
    check("R9 set wins", status, 1);
    check("R6 reload", count, 0);
    irq_en = 0; #1;
    check("R8 gated", irq, 0);
    irq_en = 1; #1;
    check("R8 raised", irq, 1);
    ctl(0, 0, 2'b00, 0, 1);
    #3;
    check("R9 clear", status, 0);
    check("R8 after clear", irq, 0);

    // random trials against closed-form expectations
    for (int i = 0; i < 24; i++) begin
      int sc = $urandom_range(0, 2);
      bit md = 1'($urandom_range(0, 1));
      int t  = $urandom_range(0, 6);
      int p  = period_of(sc);
      int n  = $urandom_range(0, (t + 3) * p);
      bit st;
      irq_en  = 1'($urandom_range(0, 1));
      ctl(0, 0, 2'b00, 0, 1);
      timeout = 16'(t);
      ctl(1, md, 2'(sc), 1, 0);
      wait_edges(n);
      st = exp_status(n, p, t);
      check(md ? "R6 count" : "R5 count", count, exp_count(n, p, t, md));
      check("R5 R6 status", status, st);
      check("R5 timer_on", timer_on, md ? 1 : !st);
      check("R8 irq", irq, st && irq_en);
    end

    summary();
  end
endmodule